// File: doc/BRIEF.md
# Paged Flash Programming Controller

This block lets a host program a small word-organised flash through a byte-addressed data space. The host first writes an operation code into a command register. It then writes any byte into the mapped flash window, and that write starts the operation. The block splits the window offset into a page number, a word index inside the page and a low/high byte select. It fills a page latch byte by byte, commits the latch to a page, erases one page or erases the whole array. A flash array stub with fixed, parameterised latencies is built in.

While an operation runs, a busy flag is set. During that time the command register is locked, writes into the window are dropped, and reads of the window stall until the array is free again. Only writes that come from the external programming port can change the command or the array. Writes that come from the internal port are always refused. Reads are served to both ports.

Top module: `flash_prog_ctrl`

## Requirements
- R1: After reset, every array word reads as 0xFFFF, the command register reads 0x00 and busy is 0. The command register is at byte address CMD_ADDR (default 0x010) and the status register is at CSR_ADDR (default 0x011). The busy flag is bit 0 of the status register.
- R2: Opcodes are 0x00 no-op, 0x01 latch load, 0x02 page write, 0x03 page erase and 0x04 chip erase. Any other value is stored and reads back, but a window write under that value starts nothing and changes nothing.
- R3: The window starts at BASE (default 0x400) and spans PAGES*PAGE_WORDS*2 bytes. For an offset from BASE, bit 0 selects the low (0) or high (1) byte, bits 4:1 select the word in a 16-word page, and the bits above those select the page.
- R4: With opcode 0x01, a window write stores its byte into the page latch at the word and byte half given by the address. Busy does not rise and the array does not change.
- R5: With opcode 0x02, a window write holds busy at 1 for exactly T_WRITE cycles. It then copies the whole latch into the page given by that address and refills the latch with 0xFFFF.
- R6: With opcode 0x03, a window write holds busy for exactly T_ERASE cycles and then sets every word of the addressed page to 0xFFFF. Other pages are left as they were.
- R7: With opcode 0x04, a window write holds busy for exactly T_ERASE cycles and then sets every word of the array to 0xFFFF.
- R8: In the cycle after a timed operation finishes, busy reads 0 and the command register reads 0x00.
- R9: While busy is set, writes to the command register are ignored.
- R10: While busy is set, writes into the window neither start an operation nor change the array or the latch.
- R11: A window read raises stall for as long as busy is set. When busy clears, the read is accepted and returns the current byte with rd_valid one cycle later. Reads of the registers never stall.
- R12: Writes with bus_ext low (internal port) never change the command register, the latch or the array, and never raise busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Byte write strobe |
| bus_rd | input | 1 | Byte read strobe, held until stall is low |
| bus_ext | input | 1 | 1 = external programming port, 0 = internal port |
| bus_addr | input | ADDR_W | Data-space byte address |
| bus_wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read completed in the previous cycle |
| stall | output | 1 | Window read is being held off by busy |
| busy | output | 1 | Timed operation in progress |

## Verification
A wrong page or word index in the address split shows up as bytes in the wrong place when the whole array is read back after each page write. The sweep reads every byte of every page, so a single misrouted bit is caught. A miscounted latency or a busy flag that clears too early shows as a wrong count of busy cycles or stall cycles, and the bench counts these exactly for every timed operation. A lock that fails during busy shows when the command register is read back during the operation, or as an extra page erased after it.

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl #(
  parameter int unsigned ADDR_W     = 12,
  parameter logic [11:0] BASE       = 12'h400,
  parameter logic [11:0] CMD_ADDR   = 12'h010,
  parameter logic [11:0] CSR_ADDR   = 12'h011,
  parameter int unsigned PAGES      = 4,
  parameter int unsigned PAGE_WORDS = 16,
  parameter int unsigned T_WRITE    = 20,
  parameter int unsigned T_ERASE    = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_ext,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  output logic              stall,
  output logic              busy
);
  localparam int unsigned WBITS = $clog2(PAGE_WORDS);
  localparam int unsigned PBITS = $clog2(PAGES);
  localparam int unsigned ABITS = WBITS + PBITS;
  localparam int unsigned WORDS = PAGES * PAGE_WORDS;
  localparam int unsigned TMAX  = (T_WRITE > T_ERASE) ? T_WRITE : T_ERASE;
  localparam int unsigned CW    = $clog2(TMAX + 1);
  localparam logic [ADDR_W-1:0] WIN_BYTES = ADDR_W'(WORDS * 2);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] CMD_A  = ADDR_W'(CMD_ADDR);
  localparam logic [ADDR_W-1:0] CSR_A  = ADDR_W'(CSR_ADDR);
  localparam logic [7:0] OP_NOP = 8'h00, OP_LOAD = 8'h01, OP_WRITE = 8'h02,
                         OP_PERASE = 8'h03, OP_CERASE = 8'h04;

  logic [15:0]       mem   [WORDS];
  logic [15:0]       latch [PAGE_WORDS];
  logic [7:0]        cmd;
  logic [CW-1:0]     cnt;
  logic [PBITS-1:0]  op_page;

  wire [ADDR_W-1:0] off    = bus_addr - BASE_A;
  wire              in_win = (bus_addr >= BASE_A) && (off < WIN_BYTES);
  wire              hi     = off[0];
  wire [WBITS-1:0]  widx   = off[WBITS:1];
  wire [PBITS-1:0]  pidx   = off[ABITS:WBITS+1];
  wire [15:0]       rword  = mem[{pidx, widx}];

  wire prog_wr  = bus_wr && bus_ext && !busy;
  wire cmd_wr   = prog_wr && (bus_addr == CMD_A);
  wire win_wr   = prog_wr && in_win;
  wire timed_op = (cmd == OP_WRITE) || (cmd == OP_PERASE) || (cmd == OP_CERASE);
  wire start_op = win_wr && timed_op;
  assign stall  = bus_rd && !bus_wr && in_win && busy;
  wire rd_acc   = bus_rd && !bus_wr && !stall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd      <= OP_NOP;
      busy     <= 1'b0;
      cnt      <= '0;
      op_page  <= '0;
      rd_valid <= 1'b0;
      rd_data  <= 8'h00;
      for (int i = 0; i < WORDS; i++) mem[i] <= 16'hFFFF;
      for (int i = 0; i < PAGE_WORDS; i++) latch[i] <= 16'hFFFF;
    end else begin
      rd_valid <= rd_acc;
      if (rd_acc) begin
        if (in_win)                rd_data <= hi ? rword[15:8] : rword[7:0];
        else if (bus_addr == CSR_A) rd_data <= {7'b0, busy};
        else if (bus_addr == CMD_A) rd_data <= cmd;
        else                        rd_data <= 8'h00;
      end
      if (cmd_wr) cmd <= bus_wdata;
      if (win_wr && cmd == OP_LOAD) begin
        if (hi) latch[widx][15:8] <= bus_wdata;
        else    latch[widx][7:0]  <= bus_wdata;
      end
      if (start_op) begin
        busy    <= 1'b1;
        cnt     <= (cmd == OP_WRITE) ? CW'(T_WRITE - 1) : CW'(T_ERASE - 1);
        op_page <= pidx;
      end
      if (busy) begin
        if (cnt == '0) begin
          busy <= 1'b0;
          cmd  <= OP_NOP;
          case (cmd)
            OP_WRITE: for (int w = 0; w < PAGE_WORDS; w++) begin
              mem[{op_page, w[WBITS-1:0]}] <= latch[w];
              latch[w] <= 16'hFFFF;
            end
            OP_PERASE: for (int w = 0; w < PAGE_WORDS; w++)
              mem[{op_page, w[WBITS-1:0]}] <= 16'hFFFF;
            OP_CERASE: for (int i = 0; i < WORDS; i++) mem[i] <= 16'hFFFF;
            default: ;
          endcase
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  AST_CMD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != '0) |=> (cmd == $past(cmd))); // R9
  AST_STALL_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> busy); // R11
  AST_NO_READ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(bus_rd && in_win)) |-> !$past(busy)); // R11
  AST_INT_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(bus_wr && bus_ext)); // R12
  AST_NOP_AFTER_OP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (cmd == OP_NOP)); // R8
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != '0) |=> busy); // R10
endmodule

// File: tb/flash_prog_ctrl_test.sv
module flash_prog_ctrl_test;
  localparam int TW = 20, TE = 30, NP = 4, PW = 16;
  logic clk = 0, rst_n = 0, bus_wr = 0, bus_rd = 0, bus_ext = 1;
  logic [11:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  rd_data;
  logic        rd_valid, stall, busy;
  int n_run = 0, n_fail = 0;
  logic [15:0] model [NP*PW];
  logic [7:0]  got;
  int          nst, nb;

  flash_prog_ctrl #(.T_WRITE(TW), .T_ERASE(TE)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_ext(bus_ext),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_data(rd_data),
    .rd_valid(rd_valid), .stall(stall), .busy(busy));

  always #10 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] wa(input int p, input int w, input int b);
    return 12'(12'h400 + p*32 + w*2 + b);
  endfunction

  function automatic logic [7:0] pat(input int p, input int w, input int b);
    return 8'((p*37 + w*11 + b*101 + 3) % 256);
  endfunction

  task automatic wr(input logic [11:0] a, input logic [7:0] d, input logic ext);
    bus_addr = a; bus_wdata = d; bus_ext = ext; bus_wr = 1;
    @(posedge clk); @(negedge clk);
    bus_wr = 0; bus_ext = 1;
  endtask

  task automatic rd(input logic [11:0] a, output logic [7:0] d, output int ns);
    bus_addr = a; bus_rd = 1; ns = 0;
    #1;
    while (stall && ns < 1000) begin @(negedge clk); ns++; end
    @(negedge clk);
    check("R11 rd_valid", int'(rd_valid), 1);
    d = rd_data;
    bus_rd = 0;
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy && n < 1000) begin @(negedge clk); n++; end
  endtask

  task automatic check_all(input string req);
    for (int p = 0; p < NP; p++)
      for (int w = 0; w < PW; w++)
        for (int b = 0; b < 2; b++) begin
          rd(wa(p, w, b), got, nst);
          check(req, int'(got), int'(b ? model[p*PW+w][15:8] : model[p*PW+w][7:0]));
        end
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < NP*PW; i++) model[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1 busy", int'(busy), 0);
    check("R1 stall", int'(stall), 0);
    rd(12'h011, got, nst); check("R1 csr", int'(got), 0);
    rd(12'h010, got, nst); check("R1 cmd", int'(got), 0);
    check_all("R1 erased");
    // R2 unknown opcode
    wr(12'h010, 8'h5A, 1);
    rd(12'h010, got, nst); check("R2 readback", int'(got), 8'h5A);
    wr(wa(1, 3, 0), 8'h00, 1);
    check("R2 no busy", int'(busy), 0);
    rd(wa(1, 3, 0), got, nst); check("R2 no change", int'(got), 8'hFF);
    // R3 R4 R5 R8 sweep of page writes
    for (int p = 0; p < NP; p++) begin
      wr(12'h010, 8'h01, 1);
      for (int w = 0; w < PW; w++)
        for (int b = 0; b < 2; b++) wr(wa((p + 1) % NP, w, b), pat(p, w, b), 1);
      check("R4 load no busy", int'(busy), 0);
      rd(wa(p, 0, 0), got, nst);
      check("R4 array untouched", int'(got), int'(model[p*PW][7:0]));
      wr(12'h010, 8'h02, 1);
      wr(wa(p, 5, 1), 8'h00, 1);
      count_busy(nb); check("R5 write cycles", nb, TW);
      rd(12'h010, got, nst); check("R8 cmd nop", int'(got), 0);
      rd(12'h011, got, nst); check("R8 csr idle", int'(got), 0);
      for (int w = 0; w < PW; w++) model[p*PW+w] = {pat(p, w, 1), pat(p, w, 0)};
      check_all("R3 placement");
    end
    // R5 latch refilled with 0xFFFF after a commit
    wr(12'h010, 8'h02, 1);
    wr(wa(0, 0, 0), 8'h00, 1);
    count_busy(nb); check("R5 write cycles", nb, TW);
    for (int w = 0; w < PW; w++) model[w] = 16'hFFFF;
    check_all("R5 latch refill");
    // R6 page erase with R9 R10 during busy
    wr(12'h010, 8'h03, 1);
    wr(wa(2, 7, 0), 8'h00, 1);
    rd(12'h010, got, nst); check("R9 cmd during busy", int'(got), 3);
    wr(12'h010, 8'h04, 1);
    rd(12'h010, got, nst); check("R9 cmd locked", int'(got), 3);
    rd(12'h011, got, nst); check("R11 csr no stall", nst, 0);
    check("R1 csr busy bit", int'(got), 1);
    wr(wa(1, 0, 0), 8'h00, 1);
    count_busy(nb);
    check("R10 no extra busy", int'(busy), 0);
    for (int w = 0; w < PW; w++) model[2*PW+w] = 16'hFFFF;
    check_all("R6 R10 page erase");
    // R11 exact stall length
    wr(12'h010, 8'h03, 1);
    wr(wa(3, 0, 0), 8'h00, 1);
    rd(wa(3, 4, 1), got, nst);
    check("R11 stall cycles", nst, TE);
    check("R11 data after erase", int'(got), 8'hFF);
    for (int w = 0; w < PW; w++) model[3*PW+w] = 16'hFFFF;
    // R12 internal port
    wr(12'h010, 8'h02, 0);
    rd(12'h010, got, nst); check("R12 cmd refused", int'(got), 0);
    wr(12'h010, 8'h03, 1);
    wr(wa(1, 2, 0), 8'h00, 0);
    check("R12 no busy", int'(busy), 0);
    rd(12'h010, got, nst); check("R12 cmd kept", int'(got), 3);
    wr(12'h010, 8'h00, 1);
    check_all("R12 array intact");
    // R7 chip erase
    wr(12'h010, 8'h04, 1);
    wr(wa(0, 0, 0), 8'h00, 1);
    count_busy(nb); check("R7 erase cycles", nb, TE);
    for (int i = 0; i < NP*PW; i++) model[i] = 16'hFFFF;
    check_all("R7 chip erase");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule